// File: doc/BRIEF.md
# Single/Double Mode Barrel Shifter

This block is the shift unit of a 32-bit microprogrammed data path. Each operation is started by a one-cycle strobe. The strobe carries a 4-bit shift code and a 7-bit shift amount, both taken from the microinstruction. In single mode the block shifts the 32-bit shifter input. In double mode it joins the ALU output (upper half) and the shifter input (lower half) into one 64-bit operand. The two logical double shifts also include a carry bit below the lowest bit, which makes the operand 65 bits wide.

Every result is registered. The new value of the shifter output, the upper-half output, the carry output and four status flags appears one clock after a legal strobe, together with a one-cycle done pulse. The ALU, the register file and the bus gating are outside the block.

Top module: `dual_width_shifter`

## Requirements
- R1: While reset is held low, every data output and every flag is 0. The done and illegal-amount pulses are also 0.
- R2: A legal strobe updates all outputs on the next rising clock edge, and done is 1 for exactly that one cycle. Without a strobe the outputs hold their values.
- R3: Any code that is not one of the ten shift codes is a pass-through. The shifter output takes the shifter input, the upper-half output takes the ALU output, and the carry output takes the carry input. The amount is ignored.
- R4: Single logical shifts, code 0100 for left and 0101 for right, move the 32-bit shifter input by 0 to 32 places and fill with zeros.
- R5: Single circular shifts, code 1100 for left and 1101 for right, rotate the 32-bit shifter input by 0 to 32 places.
- R6: Single arithmetic right, code 1001, shifts by 0 to 32 places and fills with copies of bit 31. In every single mode the upper-half output takes the ALU output and the carry output takes the carry input.
- R7: Double circular shifts, code 1110 for left and 1111 for right, rotate {ALU, shifter input} (ALU in bits 63..32) by 0 to 64 places. Bits 63..32 of the result go to the upper-half output and bits 31..0 go to the shifter output.
- R8: Double logical shifts, code 0110 for left and 0111 for right, shift the 65-bit value {ALU, shifter input, carry in} by 0 to 64 places and fill with zeros. The result is split as {upper-half out, shifter out, carry out}.
- R9: Double arithmetic right, code 1011, shifts {ALU, shifter input} by 0 to 64 places and fills with copies of bit 63. It passes the carry input to the carry output.
- R10: An amount above 32 with a single code, or above 64 with a double code, is illegal. The illegal pulse is then 1 for one cycle, one clock after the strobe. Done stays 0, and all outputs and flags keep their previous values.
- R11: The sign flag equals bit 31 of the upper-half output. For the 65-bit mode this is bit 64 of the result. The high-bit flag equals bit 31 of the shifter output, and the low-bit flag equals bit 0 of the shifter output.
- R12: The nonzero flag is the OR of upper-half output bits 30..0 in single and pass-through modes. In double modes it is the OR of upper-half output bits 30..0 and all 32 shifter output bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opStrobe | input | 1 | Starts one operation |
| shiftCode | input | 4 | Shift type, direction and mode |
| shiftAmt | input | 7 | Number of places to shift |
| aluIn | input | 32 | ALU output, the upper half of a double operand |
| shiftIn | input | 32 | Shifter input bus, the lower half of a double operand |
| carryIn | input | 1 | Carry bit below the 64-bit operand |
| shiftOut | output | 32 | Shifter output bus |
| highOut | output | 32 | Upper-half output bus |
| carryOut | output | 1 | Carry result |
| signFlag | output | 1 | Sign flag |
| nonzeroFlag | output | 1 | Result nonzero flag |
| hiBitFlag | output | 1 | Top bit of the shifter output |
| loBitFlag | output | 1 | Bottom bit of the shifter output |
| done | output | 1 | Pulse: outputs were just updated |
| illegalAmt | output | 1 | Pulse: the strobe's amount was out of range |

## Verification
The assertions check the timing and holding rules on every cycle. Done may only follow a strobe, and it never coincides with an illegal pulse. Outputs stay frozen when there is no load or the amount was illegal. Pass-through copies both buses. The high and low flags track the shifter output.

Shift results and the nonzero flag depend on the code, the amount and the data, so only the bench scenarios can show them. The bench compares every result against a bit-by-bit reference model. It covers all ten shift codes, the amounts 0, 32 and 64, the first illegal amounts 33 and 65, and the carry bit moving through the 65-bit path.

// File: rtl/shf_pkg.sv
package shf_pkg;

  typedef enum logic [2:0] {
    K_PASS,
    K_LSL,
    K_LSR,
    K_ROL,
    K_ROR,
    K_ASR
  } shift_kind_e;

  // strobes and selections from control to datapath
  typedef struct packed {
    logic        load;
    logic        isDouble;
    shift_kind_e kind;
  } shf_ctl_t;

endpackage

// File: rtl/shf_control.sv
module shf_control
  import shf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opStrobe,
  input  logic [3:0]       shiftCode,
  input  logic [AMT_W-1:0] shiftAmt,
  output shf_ctl_t         ctl,
  output logic             done,
  output logic             illegalAmt
);

  localparam int SINGLE_MAX = DATA_W;
  localparam int DOUBLE_MAX = 2 * DATA_W;

  shift_kind_e kindD;
  logic        dblD;
  logic        tooFar;

  always_comb begin
    dblD  = 1'b0;
    kindD = K_PASS;
    unique case (shiftCode)
      4'b0100: kindD = K_LSL;
      4'b0101: kindD = K_LSR;
      4'b1100: kindD = K_ROL;
      4'b1101: kindD = K_ROR;
      4'b1001: kindD = K_ASR;
      4'b0110: begin kindD = K_LSL; dblD = 1'b1; end
      4'b0111: begin kindD = K_LSR; dblD = 1'b1; end
      4'b1110: begin kindD = K_ROL; dblD = 1'b1; end
      4'b1111: begin kindD = K_ROR; dblD = 1'b1; end
      4'b1011: begin kindD = K_ASR; dblD = 1'b1; end
      default: kindD = K_PASS;
    endcase
  end

  always_comb begin
    if (kindD == K_PASS) tooFar = 1'b0;
    else if (dblD)       tooFar = int'(shiftAmt) > DOUBLE_MAX;
    else                 tooFar = int'(shiftAmt) > SINGLE_MAX;
  end

  assign ctl.load     = opStrobe && !tooFar;
  assign ctl.isDouble = dblD;
  assign ctl.kind     = kindD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done       <= 1'b0;
      illegalAmt <= 1'b0;
    end else begin
      done       <= opStrobe && !tooFar;
      illegalAmt <= opStrobe && tooFar;
    end
  end

  // R2: a done pulse is always preceded by a strobe
  p_done_after_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(opStrobe));

  // R10: one operation cannot be both completed and rejected
  p_done_illegal_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(done && illegalAmt));

endmodule

// File: rtl/shf_datapath.sv
module shf_datapath
  import shf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  shf_ctl_t          ctl,
  input  logic [AMT_W-1:0]  shiftAmt,
  input  logic [DATA_W-1:0] aluIn,
  input  logic [DATA_W-1:0] shiftIn,
  input  logic              carryIn,
  output logic [DATA_W-1:0] shiftOut,
  output logic [DATA_W-1:0] highOut,
  output logic              carryOut,
  output logic              signFlag,
  output logic              nonzeroFlag,
  output logic              hiBitFlag,
  output logic              loBitFlag
);

  localparam int DW  = 2 * DATA_W;
  localparam int CW  = DW + 1;
  localparam int QW  = 2 * DW;

  logic [DATA_W-1:0] sNext, hNext;
  logic              cNext;
  logic [DW-1:0]     pair;
  logic [CW-1:0]     pairC, tmpC;
  logic [DW-1:0]     tmpD;
  logic [QW-1:0]     tmpQ;
  logic [DW-1:0]     tmpS2;

  assign pair  = {aluIn, shiftIn};
  assign pairC = {aluIn, shiftIn, carryIn};

  always_comb begin
    sNext = shiftIn;
    hNext = aluIn;
    cNext = carryIn;
    tmpC  = '0;
    tmpD  = '0;
    tmpQ  = '0;
    tmpS2 = '0;
    if (!ctl.isDouble) begin
      unique case (ctl.kind)
        K_LSL: sNext = shiftIn << shiftAmt;
        K_LSR: sNext = shiftIn >> shiftAmt;
        K_ROL: begin tmpS2 = {shiftIn, shiftIn} << shiftAmt; sNext = tmpS2[DW-1:DATA_W]; end
        K_ROR: begin tmpS2 = {shiftIn, shiftIn} >> shiftAmt; sNext = tmpS2[DATA_W-1:0]; end
        K_ASR: sNext = $unsigned($signed(shiftIn) >>> shiftAmt);
        default: sNext = shiftIn;
      endcase
    end else begin
      unique case (ctl.kind)
        K_LSL: begin tmpC = pairC << shiftAmt; {hNext, sNext, cNext} = tmpC; end
        K_LSR: begin tmpC = pairC >> shiftAmt; {hNext, sNext, cNext} = tmpC; end
        K_ROL: begin tmpQ = {pair, pair} << shiftAmt; {hNext, sNext} = tmpQ[QW-1:DW]; end
        K_ROR: begin tmpQ = {pair, pair} >> shiftAmt; {hNext, sNext} = tmpQ[DW-1:0]; end
        K_ASR: begin tmpD = $unsigned($signed(pair) >>> shiftAmt); {hNext, sNext} = tmpD; end
        default: begin sNext = shiftIn; hNext = aluIn; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftOut    <= '0;
      highOut     <= '0;
      carryOut    <= 1'b0;
      signFlag    <= 1'b0;
      nonzeroFlag <= 1'b0;
      hiBitFlag   <= 1'b0;
      loBitFlag   <= 1'b0;
    end else if (ctl.load) begin
      shiftOut    <= sNext;
      highOut     <= hNext;
      carryOut    <= cNext;
      signFlag    <= hNext[DATA_W-1];
      nonzeroFlag <= ctl.isDouble ? (|{hNext[DATA_W-2:0], sNext}) : (|hNext[DATA_W-2:0]);
      hiBitFlag   <= sNext[DATA_W-1];
      loBitFlag   <= sNext[0];
    end
  end

  // R2: without a load the registered result does not move
  p_hold_no_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(shiftOut) && $stable(highOut) && $stable(carryOut));

  // R3: a pass-through copies both buses
  p_pass_copy_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.kind == K_PASS) |=>
      (shiftOut == $past(shiftIn)) && (highOut == $past(aluIn)));

  // R11: edge-bit flags track the shifter output
  p_edge_flags_r11: assert property (@(posedge clk) disable iff (!rstN)
    (hiBitFlag == shiftOut[DATA_W-1]) && (loBitFlag == shiftOut[0]));

  // R11: sign flag tracks the top bit of the upper half
  p_sign_flag_r11: assert property (@(posedge clk) disable iff (!rstN)
    signFlag == highOut[DATA_W-1]);

endmodule

// File: rtl/dual_width_shifter.sv
module dual_width_shifter
  import shf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opStrobe,
  input  logic [3:0]        shiftCode,
  input  logic [AMT_W-1:0]  shiftAmt,
  input  logic [DATA_W-1:0] aluIn,
  input  logic [DATA_W-1:0] shiftIn,
  input  logic              carryIn,
  output logic [DATA_W-1:0] shiftOut,
  output logic [DATA_W-1:0] highOut,
  output logic              carryOut,
  output logic              signFlag,
  output logic              nonzeroFlag,
  output logic              hiBitFlag,
  output logic              loBitFlag,
  output logic              done,
  output logic              illegalAmt
);

  shf_ctl_t ctl;

  shf_control #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_control (
    .clk(clk), .rstN(rstN), .opStrobe(opStrobe), .shiftCode(shiftCode),
    .shiftAmt(shiftAmt), .ctl(ctl), .done(done), .illegalAmt(illegalAmt)
  );

  shf_datapath #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .shiftAmt(shiftAmt),
    .aluIn(aluIn), .shiftIn(shiftIn), .carryIn(carryIn),
    .shiftOut(shiftOut), .highOut(highOut), .carryOut(carryOut),
    .signFlag(signFlag), .nonzeroFlag(nonzeroFlag),
    .hiBitFlag(hiBitFlag), .loBitFlag(loBitFlag)
  );

  // R10: a rejected amount leaves every output untouched
  p_illegal_holds_r10: assert property (@(posedge clk) disable iff (!rstN)
    illegalAmt |-> $stable(shiftOut) && $stable(highOut) && $stable(carryOut)
                   && $stable(nonzeroFlag));

endmodule

// File: tb/dual_width_shifter_bench.sv
module dual_width_shifter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opStrobe = 1'b0;
  logic [3:0] shiftCode = '0;
  logic [6:0] shiftAmt = '0;
  logic [W-1:0] aluIn = '0, shiftIn = '0;
  logic carryIn = 1'b0;
  logic [W-1:0] shiftOut, highOut;
  logic carryOut, signFlag, nonzeroFlag, hiBitFlag, loBitFlag, done, illegalAmt;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // model state
  logic [W-1:0] eS = '0, eH = '0;
  logic eC = 0;
  logic [3:0] eF = '0; // sign, nonzero, hi, lo

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_width_shifter u_dual_width_shifter (
    .clk(clk), .rstN(rstN), .opStrobe(opStrobe), .shiftCode(shiftCode),
    .shiftAmt(shiftAmt), .aluIn(aluIn), .shiftIn(shiftIn), .carryIn(carryIn),
    .shiftOut(shiftOut), .highOut(highOut), .carryOut(carryOut),
    .signFlag(signFlag), .nonzeroFlag(nonzeroFlag), .hiBitFlag(hiBitFlag),
    .loBitFlag(loBitFlag), .done(done), .illegalAmt(illegalAmt)
  );

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tagFor(input logic [3:0] c);
    case (c)
      4'b0100, 4'b0101: return "R4";
      4'b1100, 4'b1101: return "R5";
      4'b1001:          return "R6";
      4'b1110, 4'b1111: return "R7";
      4'b0110, 4'b0111: return "R8";
      4'b1011:          return "R9";
      default:          return "R3";
    endcase
  endfunction

  function automatic bit isShift(input logic [3:0] c);
    return tagFor(c) != "R3";
  endfunction

  // bit-by-bit reference of the result
  task automatic refModel(input logic [3:0] c, input int n, input logic [W-1:0] a,
                          input logic [W-1:0] s, input logic ci,
                          output logic [W-1:0] rs, output logic [W-1:0] rh, output logic rc);
    logic [64:0] v, r;
    logic [63:0] w, q;
    logic [31:0] x;
    rs = s; rh = a; rc = ci;
    v = {a, s, ci}; w = {a, s}; r = '0; q = '0; x = '0;
    case (c)
      4'b0100: begin for (int i = 0; i < 32; i++) x[i] = (i - n >= 0) ? s[i-n] : 1'b0; rs = x; end
      4'b0101: begin for (int i = 0; i < 32; i++) x[i] = (i + n <= 31) ? s[i+n] : 1'b0; rs = x; end
      4'b1100: begin for (int i = 0; i < 32; i++) x[i] = s[(i - n + 64) % 32]; rs = x; end
      4'b1101: begin for (int i = 0; i < 32; i++) x[i] = s[(i + n) % 32]; rs = x; end
      4'b1001: begin for (int i = 0; i < 32; i++) x[i] = (i + n <= 31) ? s[i+n] : s[31]; rs = x; end
      4'b0110: begin for (int i = 0; i < 65; i++) r[i] = (i - n >= 0) ? v[i-n] : 1'b0; {rh, rs, rc} = r; end
      4'b0111: begin for (int i = 0; i < 65; i++) r[i] = (i + n <= 64) ? v[i+n] : 1'b0; {rh, rs, rc} = r; end
      4'b1110: begin for (int i = 0; i < 64; i++) q[i] = w[(i - n + 128) % 64]; {rh, rs} = q; end
      4'b1111: begin for (int i = 0; i < 64; i++) q[i] = w[(i + n) % 64]; {rh, rs} = q; end
      4'b1011: begin for (int i = 0; i < 64; i++) q[i] = (i + n <= 63) ? w[i+n] : w[63]; {rh, rs} = q; end
      default: ;
    endcase
  endtask

  task automatic doOp(input logic [3:0] c, input int n, input logic [W-1:0] a,
                      input logic [W-1:0] s, input logic ci);
    logic [W-1:0] rs, rh;
    logic rc;
    bit dbl, legal;
    string t;
    t = tagFor(c);
    dbl = isShift(c) && c[1];
    legal = !isShift(c) || (dbl ? n <= 64 : n <= 32);
    @(negedge clk);
    opStrobe = 1; shiftCode = c; shiftAmt = 7'(n); aluIn = a; shiftIn = s; carryIn = ci;
    @(negedge clk);
    opStrobe = 0;
    if (legal) begin
      refModel(c, n, a, s, ci, rs, rh, rc);
      eS = rs; eH = rh; eC = rc;
      eF[3] = rh[31];
      eF[2] = dbl ? |{rh[30:0], rs} : |rh[30:0];
      eF[1] = rs[31];
      eF[0] = rs[0];
      check({t, " result"}, {63'd0, eC, eH, eS}, {63'd0, carryOut, highOut, shiftOut});
      check("R11 R12 flags", {124'd0, signFlag, nonzeroFlag, hiBitFlag, loBitFlag}, {124'd0, eF});
      check("R2 done pulse", {126'd0, done, illegalAmt}, {126'd0, 2'b10});
    end else begin
      check("R10 illegal hold", {62'd0, illegalAmt, done, carryOut, highOut, shiftOut},
            {62'd0, 2'b10, eC, eH, eS});
      check("R10 illegal flags", {124'd0, signFlag, nonzeroFlag, hiBitFlag, loBitFlag}, {124'd0, eF});
    end
  endtask

  initial begin
    for (int k = 0; k < 100000; k++) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] codes [10];
    int unsigned seed;
    codes = '{4'b0100, 4'b0101, 4'b1100, 4'b1101, 4'b1001,
              4'b0110, 4'b0111, 4'b1110, 4'b1111, 4'b1011};
    seed = 32'h1d2c3b4a;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset", {60'd0, shiftOut, highOut, carryOut, signFlag, nonzeroFlag,
          hiBitFlag, loBitFlag, done, illegalAmt}, '0);
    rstN = 1;
    // R3: pass-through with an out-of-range amount that must be ignored
    doOp(4'b0000, 100, 32'h8000_0001, 32'hdead_beef, 1'b1);
    doOp(4'b1010, 0, 32'h0000_0000, 32'h1234_5678, 1'b0);
    // R2: outputs hold with no strobe
    repeat (3) @(negedge clk);
    check("R2 hold", {64'd0, done, carryOut, highOut[30:0], shiftOut}, {64'd0, 1'b0, eC, eH[30:0], eS});
    // R4 R5 R6 boundaries
    doOp(4'b0100, 32, 32'h0, 32'hffff_ffff, 0);
    doOp(4'b0101, 0, 32'h1, 32'h8000_0001, 0);
    doOp(4'b1101, 32, 32'h0, 32'h89ab_cdef, 0);
    doOp(4'b1100, 4, 32'h0, 32'h1234_5678, 0);
    doOp(4'b1001, 32, 32'h0, 32'h8000_0000, 0);
    // R7 R8 R9 boundaries
    doOp(4'b0110, 64, 32'h0, 32'h0, 1);
    doOp(4'b0111, 64, 32'h8000_0000, 32'h0, 0);
    doOp(4'b0111, 1, 32'h0, 32'h0000_0001, 0);
    doOp(4'b1111, 64, 32'hcafe_f00d, 32'h0bad_beef, 0);
    doOp(4'b1110, 36, 32'hcafe_f00d, 32'h0bad_beef, 0);
    doOp(4'b1011, 33, 32'h8000_0000, 32'h0, 0);
    // R10 first illegal amounts
    doOp(4'b0101, 33, 32'h5, 32'h5, 1);
    doOp(4'b1111, 65, 32'h5, 32'h5, 1);
    doOp(4'b1001, 127, 32'h5, 32'h5, 1);
    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [3:0] c;
      int n;
      if ($urandom % 8 == 0) c = 4'($urandom);
      else c = codes[$urandom % 10];
      n = ($urandom % 16 == 0) ? int'($urandom % 128) : int'($urandom % 66);
      doOp(c, n, $urandom, $urandom, 1'($urandom));
    end
    finished = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule